// File: doc/BRIEF.md
# Halfword Multiply Accumulator with Round-and-Saturate

This block holds a 64-bit accumulator beside a 32-bit register datapath. Each cycle it carries out at most one operation picked by a 3-bit code: a signed 16x16 multiply of the upper or lower halfwords of two 32-bit sources, which either replaces the accumulator or is added to it; a write of the upper or lower accumulator word from a source operand; or a round-and-saturate step that leaves a 32-bit result in the upper word.

A separate read port returns the upper, middle (bits 47:16) or lower word of the accumulator. The read path is combinational from the stored value, so a read and an update may occur in the same cycle. All updates take effect at the next rising clock edge.

Top module: `mac_acc`

## Requirements
- R1: An active-low asynchronous reset clears the accumulator to zero.
- R2: Op code 1 loads the accumulator with the sign-extended signed product of src1[31:16] and src2[31:16].
- R3: Op code 2 loads the accumulator with the sign-extended signed product of src1[15:0] and src2[15:0].
- R4: Op code 3 (upper halves) and op code 4 (lower halves) add the sign-extended signed product to the accumulator, wrapping modulo 2^64.
- R5: Op code 5 writes src1 into accumulator bits 63:32 and keeps bits 31:0.
- R6: Op code 6 writes src1 into accumulator bits 31:0 and keeps bits 63:32.
- R7: The read port returns bits 63:32 for select 00, bits 47:16 for select 01, and bits 31:0 for select 10 or 11.
- R8: The read port shows the stored value of the current cycle; an update issued in that cycle appears only after the next rising edge.
- R9: Op code 7 shifts the accumulator left by 2 when the shift input is 2 and by 1 for any other value, adds 0x80000000, and clears bits 31:0 of the result.
- R10: If that sum, read as signed, exceeds 0x00007FFF_00000000, the accumulator becomes 0x00007FFF_00000000.
- R11: If that sum, read as signed, is below 0xFFFF8000_00000000, the accumulator becomes 0xFFFF8000_00000000.
- R12: Op code 0 leaves the accumulator unchanged whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| src1_i | input | 32 | First source operand |
| src2_i | input | 32 | Second source operand |
| shamt_i | input | 2 | Shift amount for round-and-saturate |
| rd_sel_i | input | 2 | Word select for the read port |
| rd_data_o | output | 32 | Selected accumulator word |

## Verification
A read and an update can fall in the same cycle. This matters because the read port must return the value held before the update. The bench provokes this by issuing an upper-word write with the read select on the upper word. It samples the read port just before the rising edge and expects the old word there. After the edge it expects the new word. The round step's clamps are reached from both sides with shift amounts of 1, 2 and an out-of-range 3.

// File: rtl/mac_acc_pkg.sv
package mac_acc_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = 16;
  localparam int SH_W   = 2;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_MUL_HI = 3'd1,
    OP_MUL_LO = 3'd2,
    OP_MAC_HI = 3'd3,
    OP_MAC_LO = 3'd4,
    OP_WR_HI  = 3'd5,
    OP_WR_LO  = 3'd6,
    OP_RND    = 3'd7
  } acc_op_e;
endpackage

// File: rtl/mac_acc_mult.sv
module mac_acc_mult #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  localparam int ACC_W = 2 * DATA_W,
  localparam int PRD_W = 2 * HALF_W
) (
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic              use_hi_i,
  output logic [ACC_W-1:0]  prod_o
);
  logic signed [HALF_W-1:0] a_h, b_h;
  logic signed [PRD_W-1:0]  p;

  assign a_h = use_hi_i ? src1_i[DATA_W-1 -: HALF_W] : src1_i[HALF_W-1:0];
  assign b_h = use_hi_i ? src2_i[DATA_W-1 -: HALF_W] : src2_i[HALF_W-1:0];
  assign p   = a_h * b_h;
  assign prod_o = {{(ACC_W-PRD_W){p[PRD_W-1]}}, p};
endmodule

// File: rtl/mac_acc_round.sv
module mac_acc_round #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int SH_W   = 2,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [ACC_W-1:0] res_o
);
  localparam logic [ACC_W-1:0] RND_K = ACC_W'(1) << (DATA_W - 1);
  localparam logic [ACC_W-1:0] HI_LIM =
    ACC_W'((ACC_W'(1) << (HALF_W - 1)) - ACC_W'(1)) << DATA_W;
  localparam logic [ACC_W-1:0] LO_LIM = ~HI_LIM - ((ACC_W'(1) << DATA_W) - ACC_W'(1));

  logic [ACC_W-1:0] shifted, sum;

  // only 2 selects the double shift; everything else shifts by one
  assign shifted = (shamt_i == SH_W'(2)) ? (acc_i << 2) : (acc_i << 1);
  assign sum     = shifted + RND_K;

  always_comb begin
    if ($signed(sum) > $signed(HI_LIM))      res_o = HI_LIM;
    else if ($signed(sum) < $signed(LO_LIM)) res_o = LO_LIM;
    else                                     res_o = {sum[ACC_W-1:DATA_W], {DATA_W{1'b0}}};
  end
endmodule

// File: rtl/mac_acc_rdmux.sv
module mac_acc_rdmux #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [1:0]        sel_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    unique case (sel_i)
      2'b00:   data_o = acc_i[ACC_W-1:DATA_W];
      2'b01:   data_o = acc_i[DATA_W+HALF_W-1:HALF_W];
      default: data_o = acc_i[DATA_W-1:0];
    endcase
  end
endmodule

// File: rtl/mac_acc.sv
module mac_acc
  import mac_acc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int HW = HALF_W,
  parameter int SW = SH_W,
  localparam int AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] src1_i,
  input  logic [DW-1:0] src2_i,
  input  logic [SW-1:0] shamt_i,
  input  logic [1:0]    rd_sel_i,
  output logic [DW-1:0] rd_data_o
);
  logic [AW-1:0] acc_q, acc_d, prod, rnd;
  logic          use_hi;

  assign use_hi = (op_i == OP_MUL_HI) || (op_i == OP_MAC_HI);

  mac_acc_mult #(.DATA_W(DW), .HALF_W(HW)) u_mult (
    .src1_i(src1_i), .src2_i(src2_i), .use_hi_i(use_hi), .prod_o(prod)
  );

  mac_acc_round #(.DATA_W(DW), .HALF_W(HW), .SH_W(SW)) u_round (
    .acc_i(acc_q), .shamt_i(shamt_i), .res_o(rnd)
  );

  mac_acc_rdmux #(.DATA_W(DW), .HALF_W(HW)) u_rdmux (
    .acc_i(acc_q), .sel_i(rd_sel_i), .data_o(rd_data_o)
  );

  always_comb begin
    unique case (op_i)
      OP_MUL_HI, OP_MUL_LO: acc_d = prod;
      OP_MAC_HI, OP_MAC_LO: acc_d = acc_q + prod;
      OP_WR_HI:             acc_d = {src1_i, acc_q[DW-1:0]};
      OP_WR_LO:             acc_d = {acc_q[AW-1:DW], src1_i};
      OP_RND:               acc_d = rnd;
      default:              acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end
endmodule

// File: rtl/mac_acc_chk.sv
module mac_acc_chk
  import mac_acc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int HW = HALF_W,
  localparam int AW = 2 * DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    op_i,
  input logic [DW-1:0] src1_i,
  input logic [DW-1:0] src2_i,
  input logic [1:0]    rd_sel_i,
  input logic [DW-1:0] rd_data_o,
  input logic [AW-1:0] acc_q
);
  localparam logic [AW-1:0] UP_B = 64'h00007FFF_00000000;
  localparam logic [AW-1:0] DN_B = 64'hFFFF8000_00000000;

  function automatic logic [AW-1:0] sx_mul(logic [HW-1:0] x, logic [HW-1:0] y);
    logic signed [2*HW-1:0] p;
    p = $signed(x) * $signed(y);
    return {{(AW-2*HW){p[2*HW-1]}}, p};
  endfunction

  a_r2_mul_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_MUL_HI |=> acc_q == sx_mul($past(src1_i[DW-1 -: HW]), $past(src2_i[DW-1 -: HW])));

  a_r4_mac_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_MAC_LO |=> acc_q == $past(acc_q) + sx_mul($past(src1_i[HW-1:0]), $past(src2_i[HW-1:0])));

  a_r5_wr_hi_keeps_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_WR_HI |=> acc_q[DW-1:0] == $past(acc_q[DW-1:0]));

  a_r6_wr_lo_keeps_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_WR_LO |=> acc_q[AW-1:DW] == $past(acc_q[AW-1:DW]));

  a_r9_round_clears_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_RND |=> acc_q[DW-1:0] == '0);

  a_r10_r11_round_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_RND |=> ($signed(acc_q) <= $signed(UP_B)) && ($signed(acc_q) >= $signed(DN_B)));

  a_r12_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_IDLE |=> $stable(acc_q));

  a_r8_read_hi_current: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i == 2'b00 |-> rd_data_o == acc_q[AW-1:DW]);
endmodule

bind mac_acc mac_acc_chk #(.DW(DW), .HW(HW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .src1_i(src1_i), .src2_i(src2_i),
  .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .acc_q(acc_q)
);

// File: tb/test_mac_acc.sv
`timescale 1ns/100ps
module test_mac_acc;
  import mac_acc_pkg::*;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [1:0]  sh;
    logic [4:0]  req;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{OP_MUL_HI, 32'h00031234, 32'hFFFE5678, 2'd0, 5'd2,  64'hFFFFFFFF_FFFFFFFA}, // R2
    '{OP_MAC_HI, 32'h00100000, 32'h00100000, 2'd0, 5'd4,  64'h00000000_000000FA}, // R4
    '{OP_MUL_LO, 32'hAAAA8000, 32'h55558000, 2'd0, 5'd3,  64'h00000000_40000000}, // R3
    '{OP_MAC_LO, 32'h00007FFF, 32'h00007FFF, 2'd0, 5'd4,  64'h00000000_7FFF0001}, // R4
    '{OP_WR_HI,  32'h12345678, 32'h0,        2'd0, 5'd5,  64'h12345678_7FFF0001}, // R5
    '{OP_WR_LO,  32'hDEADBEEF, 32'h0,        2'd0, 5'd6,  64'h12345678_DEADBEEF}, // R6
    '{OP_WR_HI,  32'h00000000, 32'h0,        2'd0, 5'd5,  64'h00000000_DEADBEEF}, // R5
    '{OP_RND,    32'h0,        32'h0,        2'd1, 5'd9,  64'h00000002_00000000}, // R9
    '{OP_IDLE,   32'hFFFFFFFF, 32'hFFFFFFFF, 2'd2, 5'd12, 64'h00000002_00000000}, // R12
    '{OP_WR_LO,  32'hC0000000, 32'h0,        2'd0, 5'd6,  64'h00000002_C0000000}, // R6
    '{OP_RND,    32'h0,        32'h0,        2'd3, 5'd9,  64'h00000006_00000000}, // R9 shift 3 acts as 1
    '{OP_WR_LO,  32'h40000000, 32'h0,        2'd0, 5'd6,  64'h00000006_40000000}, // R6
    '{OP_RND,    32'h0,        32'h0,        2'd2, 5'd9,  64'h00000019_00000000}, // R9 shift 2
    '{OP_WR_HI,  32'h00007FFF, 32'h0,        2'd0, 5'd5,  64'h00007FFF_00000000}, // R5
    '{OP_WR_LO,  32'h80000000, 32'h0,        2'd0, 5'd6,  64'h00007FFF_80000000}, // R6
    '{OP_RND,    32'h0,        32'h0,        2'd1, 5'd10, 64'h00007FFF_00000000}, // R10
    '{OP_WR_HI,  32'hFFFFC000, 32'h0,        2'd0, 5'd5,  64'hFFFFC000_00000000}, // R5
    '{OP_RND,    32'h0,        32'h0,        2'd2, 5'd11, 64'hFFFF8000_00000000}, // R11
    '{OP_MAC_LO, 32'h0000FFFF, 32'h00000001, 2'd0, 5'd4,  64'hFFFF7FFF_FFFFFFFF}  // R4
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op = OP_IDLE;
  logic [31:0] src1 = '0, src2 = '0;
  logic [1:0]  shamt = '0, rd_sel = '0;
  logic [31:0] rd_data;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  mac_acc i_mac_acc (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .src1_i(src1), .src2_i(src2),
    .shamt_i(shamt), .rd_sel_i(rd_sel), .rd_data_o(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  // read all three words through the port (R7); op is idle meanwhile
  task automatic chk_acc(input string tag, input logic [63:0] exp);
    rd_sel = 2'b00; #0.3; chk({tag, " hi"},  rd_data, exp[63:32]);
    rd_sel = 2'b01; #0.3; chk({tag, " R7 mid"}, rd_data, exp[47:16]);
    rd_sel = 2'b10; #0.3; chk({tag, " lo"},  rd_data, exp[31:0]);
    rd_sel = 2'b11; #0.3; chk({tag, " R7 sel3"}, rd_data, exp[31:0]);
  endtask

  task automatic do_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] s);
    @(negedge clk);
    op = o; src1 = a; src2 = b; shamt = s;
    @(posedge clk);
    #0.3 op = OP_IDLE;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk_acc("R1 reset", 64'h0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].sh);
      chk_acc($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].exp);
    end

    // R8: read and write in the same cycle
    @(negedge clk);
    op = OP_WR_HI; src1 = 32'hCAFEF00D; rd_sel = 2'b00;
    #1.5 chk("R8 before edge", rd_data, 32'hFFFF7FFF);
    @(posedge clk);
    #0.3 op = OP_IDLE;
    chk("R8 after edge", rd_data, 32'hCAFEF00D);

    // R1: asynchronous reset mid-run
    #0.5 rst_ni = 1'b0;
    #0.3 chk_acc("R1 async", 64'h0);
    @(negedge clk) rst_ni = 1'b1;

    // R3 sign: low halves positive * negative
    do_op(OP_MUL_LO, 32'hFFFF0002, 32'h7FFFFFFD, 2'd0);
    chk_acc("R3 neg", 64'hFFFFFFFF_FFFFFFFA);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule